// File: doc/BRIEF.md
# Virtual-Time Latency Emulator

This block keeps an emulated execution clock for a memory hierarchy model that runs on a fixed physical clock. Each time an access completes, the access port reports the level that serviced it: first-level hit, second-level hit or main memory. The block then adds that level's programmable latency to a 64-bit virtual-time accumulator. A separate port reports compute time spent between memory operations, and that time is added to the same accumulator. Because of this, the reported target execution time depends only on the programmed latencies and never on the physical clock rate.

Software reaches the block through a simple word-addressed register port. Writes set the three latencies and can clear all accumulated state in one cycle. Reads return the accumulated time and one saturating completion counter per level. Reading the low half of the time captures the high half at the same moment, so two reads give a consistent 64-bit value.

Top module: `vtime_emu`

## Requirements
- R1: After reset the latencies read back as 1 (address 1, first level), 8 (address 2, second level) and 60 (address 3, main memory), and the time words and all three counters read 0.
- R2: A cycle with `acc_valid` high adds the latency of the level coded on `acc_level` to the accumulated time. The codes are 0 for first level, 1 for second level and 2 for main memory. Code 3 adds nothing and counts nothing.
- R3: A cycle with `cmp_valid` high adds `cmp_cycles` to the accumulated time. If an access arrives in the same cycle, both amounts are added.
- R4: Each level has its own counter (address 6 first level, 7 second level, 8 main memory). It increments once per completion of that level and holds at its maximum value instead of wrapping.
- R5: A write to address 1, 2 or 3 sets that level's latency from the low LAT_W bits of `wr_data`. The new value is used for accesses from the following cycle onward.
- R6: A read of address 4 returns bits 31:0 of the time and captures bits 63:32 at the same instant. A read of address 5 returns that captured value and stays unchanged while the time advances, until the next read of address 4.
- R7: A write to address 0 with bit 0 set clears the time and all counters. Accesses and compute time presented in that same cycle are dropped.
- R8: Read data appears on `rd_data` in the cycle after `rd_en`. Addresses 0 and 9 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Physical clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access completion event |
| acc_level | input | 2 | Level that serviced the access |
| cmp_valid | input | 1 | Compute time report |
| cmp_cycles | input | 32 | Compute time in virtual cycles |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data, one cycle after rd_en |

## Verification
Single accesses at each level code, including the unused code, show whether the correct latency is selected and whether the right counter moves. Access and compute time presented together, and a clear issued in the same cycle as both, separate a summing adder from one that only takes one source, and they show whether clear wins over pending events. Two large compute-time additions push the carry into the upper word, which tests the capture of the high half across reads. A long run of first-level hits reaches counter saturation, and a seeded random mix of levels, compute amounts and latency rewrites is compared against a bench model of the total time and counts.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic [1:0] {
    LVL_NEAR = 2'd0,
    LVL_MID  = 2'd1,
    LVL_FAR  = 2'd2,
    LVL_NONE = 2'd3
  } lvl_e;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_LAT0  = 4'd1;
  localparam logic [3:0] A_TLO   = 4'd4;
  localparam logic [3:0] A_THI   = 4'd5;
  localparam logic [3:0] A_CNT0  = 4'd6;
  localparam int         N_LVL   = 3;
endpackage

// File: rtl/vt_lat_regs.sv
module vt_lat_regs #(
  parameter int LAT_W  = 16,
  parameter int DEF_L0 = 1,
  parameter int DEF_L1 = 8,
  parameter int DEF_L2 = 60
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [3:0]            wr_addr,
  input  logic [LAT_W-1:0]      wr_val,
  output logic [2:0][LAT_W-1:0] lat
);
  import vt_pkg::*;
  logic [2:0][LAT_W-1:0] lat_d;
  logic [2:0][LAT_W-1:0] lat_q;

  always_comb begin
    lat_d = lat_q;
    for (int i = 0; i < N_LVL; i++)
      if (wr_en && wr_addr == A_LAT0 + 4'(i)) lat_d[i] = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q[0] <= LAT_W'(DEF_L0);
      lat_q[1] <= LAT_W'(DEF_L1);
      lat_q[2] <= LAT_W'(DEF_L2);
    end else begin
      lat_q <= lat_d;
    end
  end

  assign lat = lat_q;

  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lat_q)) else $error("latency changed without write"); // R5
endmodule

// File: rtl/vt_sat_counter.sv
module vt_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;
  logic [W-1:0] cnt_q;
  logic         at_max;

  assign at_max = &cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (inc && !at_max) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !clr) |=> &cnt_q) else $error("counter wrapped"); // R4
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0) else $error("counter not cleared"); // R7
endmodule

// File: rtl/vt_accum.sv
module vt_accum #(
  parameter int VT_W  = 64,
  parameter int ADD_W = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [ADD_W-1:0] add_val,
  output logic [VT_W-1:0]  vt
);
  logic [VT_W-1:0] vt_d;
  logic [VT_W-1:0] vt_q;

  always_comb begin
    vt_d = vt_q;
    if (clr)         vt_d = '0;
    else if (add_en) vt_d = vt_q + VT_W'(add_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vt_q <= '0;
    else        vt_q <= vt_d;
  end

  assign vt = vt_q;

  AST_VT_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> vt_q >= $past(vt_q)) else $error("virtual time went back"); // R2
  AST_VT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> vt_q == '0) else $error("virtual time not cleared"); // R7
endmodule

// File: rtl/vtime_emu.sv
module vtime_emu #(
  parameter int LAT_W = 16,
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic [1:0]  acc_level,
  input  logic        cmp_valid,
  input  logic [31:0] cmp_cycles,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data
);
  import vt_pkg::*;
  localparam int VT_W  = 64;
  localparam int ADD_W = 33;
  localparam int HALF  = VT_W / 2;

  logic [2:0][LAT_W-1:0] lat;
  logic [VT_W-1:0]       vt;
  logic [2:0][CNT_W-1:0] cnt;
  logic                  clr;
  logic                  lvl_ok;
  logic [ADD_W-1:0]      add_val;
  logic                  add_en;
  logic [HALF-1:0]       hi_d, hi_q;
  logic [31:0]           rd_d, rd_q;
  logic                  lo_read;

  assign clr    = wr_en && wr_addr == A_CTRL && wr_data[0];
  assign lvl_ok = acc_valid && lvl_e'(acc_level) != LVL_NONE;

  always_comb begin
    add_val = '0;
    if (lvl_ok)    add_val = ADD_W'(lat[acc_level]);
    if (cmp_valid) add_val = add_val + ADD_W'(cmp_cycles);
  end
  assign add_en = !clr && (lvl_ok || cmp_valid);

  vt_lat_regs #(.LAT_W(LAT_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_val(wr_data[LAT_W-1:0]), .lat(lat)
  );

  vt_accum #(.VT_W(VT_W), .ADD_W(ADD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .add_en(add_en),
    .add_val(add_val), .vt(vt)
  );

  for (genvar g = 0; g < N_LVL; g++) begin : g_cnt
    logic inc_g;
    assign inc_g = !clr && acc_valid && acc_level == 2'(g);
    vt_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc_g), .cnt(cnt[g])
    );
  end

  assign lo_read = rd_en && rd_addr == A_TLO;

  always_comb begin
    hi_d = lo_read ? vt[VT_W-1:HALF] : hi_q;
    rd_d = rd_q;
    if (rd_en) begin
      rd_d = '0;
      if (rd_addr >= A_LAT0 && rd_addr < A_LAT0 + 4'(N_LVL))
        rd_d = 32'(lat[rd_addr - A_LAT0]);
      else if (rd_addr == A_TLO)
        rd_d = vt[HALF-1:0];
      else if (rd_addr == A_THI)
        rd_d = hi_q;
      else if (rd_addr >= A_CNT0 && rd_addr < A_CNT0 + 4'(N_LVL))
        rd_d = 32'(cnt[rd_addr - A_CNT0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      rd_q <= '0;
    end else begin
      hi_q <= hi_d;
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_read |=> $stable(hi_q)) else $error("captured high word moved"); // R6
  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    lo_read |=> hi_q == $past(vt[VT_W-1:HALF])) else $error("high word not captured"); // R6
endmodule

// File: tb/vtime_emu_bench.sv
module vtime_emu_bench;
  localparam int CW = 8;
  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid, cmp_valid, wr_en, rd_en;
  logic [1:0] acc_level;
  logic [31:0] cmp_cycles, wr_data, rd_data;
  logic [3:0] wr_addr, rd_addr;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [63:0] m_vt;
  logic [15:0] m_lat [3];
  int m_cnt [3];
  logic [31:0] m_hi;

  always #5 clk = ~clk;

  vtime_emu #(.LAT_W(16), .CNT_W(CW)) u_vtime_emu (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_level(acc_level),
    .cmp_valid(cmp_valid), .cmp_cycles(cmp_cycles), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  function automatic int sat_inc(int v);
    return (v >= (1 << CW) - 1) ? v : v + 1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(bit ev, logic [1:0] lv, bit cv, logic [31:0] cy,
                       bit wv, logic [3:0] wa, logic [31:0] wd);
    @(negedge clk);
    acc_valid = ev; acc_level = lv; cmp_valid = cv; cmp_cycles = cy;
    wr_en = wv; wr_addr = wa; wr_data = wd;
    if (wv && wa == 4'd0 && wd[0]) begin
      m_vt = '0;
      for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    end else begin
      if (ev && lv != 2'd3) begin
        m_vt = m_vt + 64'(m_lat[lv]);
        m_cnt[lv] = sat_inc(m_cnt[lv]);
      end
      if (cv) m_vt = m_vt + 64'(cy);
    end
    if (wv && wa >= 4'd1 && wa <= 4'd3) m_lat[wa - 4'd1] = wd[15:0];
    @(negedge clk);
    acc_valid = 0; cmp_valid = 0; wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    if (a == 4'd4) m_hi = m_vt[63:32];
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic check_all(string req);
    logic [31:0] v;
    rd(4'd4, v); check(req, v, m_vt[31:0]);
    rd(4'd5, v); check(req, v, m_hi);
    for (int i = 0; i < 3; i++) begin
      rd(4'(6 + i), v); check(req, v, 32'(m_cnt[i]));
      rd(4'(1 + i), v); check(req, v, 32'(m_lat[i]));
    end
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int seed = 1234;
    void'($urandom(seed));
    acc_valid = 0; acc_level = 0; cmp_valid = 0; cmp_cycles = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_en = 0; rd_addr = 0;
    rst_n = 0;
    m_vt = 0; m_hi = 0;
    m_lat[0] = 1; m_lat[1] = 8; m_lat[2] = 60;
    for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state, R8 unmapped reads
    check_all("R1");
    rd(4'd0, v); check("R8", v, 0);
    rd(4'd9, v); check("R8", v, 0);
    rd(4'd15, v); check("R8", v, 0);

    // R2 each level, unused code 3
    drive(1, 2'd0, 0, 0, 0, 0, 0);
    drive(1, 2'd1, 0, 0, 0, 0, 0);
    drive(1, 2'd2, 0, 0, 0, 0, 0);
    drive(1, 2'd3, 0, 0, 0, 0, 0);
    rd(4'd4, v); check("R2", v, 32'd69);
    check_all("R2");
    // R3 compute alone and together with access
    drive(0, 0, 1, 32'd100, 0, 0, 0);
    drive(1, 2'd2, 1, 32'd5, 0, 0, 0);
    rd(4'd4, v); check("R3", v, 32'd234);
    rd(4'd8, v); check("R4", v, 32'd2);
    // R5 latency rewrite then access next cycle
    drive(0, 0, 0, 0, 1, 4'd2, 32'h0001_0014);
    drive(1, 2'd1, 0, 0, 0, 0, 0);
    rd(4'd4, v); check("R5", v, 32'd254);
    rd(4'd2, v); check("R5", v, 32'd20);
    // R7 clear with simultaneous access and compute
    drive(1, 2'd0, 1, 32'd77, 1, 4'd0, 32'd1);
    check_all("R7");
    // R6 carry into high word and capture
    drive(0, 0, 1, 32'hFFFF_FFFF, 0, 0, 0);
    drive(0, 0, 1, 32'hFFFF_FFFF, 0, 0, 0);
    rd(4'd4, v); check("R6", v, 32'hFFFF_FFFE);
    rd(4'd5, v); check("R6", v, 32'd1);
    drive(0, 0, 1, 32'd2, 0, 0, 0);
    rd(4'd5, v); check("R6", v, 32'd1);
    rd(4'd4, v); check("R6", v, 32'd0);
    rd(4'd5, v); check("R6", v, 32'd2);
    // R4 saturation
    drive(0, 0, 0, 0, 1, 4'd0, 32'd1);
    for (int i = 0; i < 260; i++) drive(1, 2'd0, 0, 0, 0, 0, 0);
    rd(4'd6, v); check("R4", v, 32'd255);
    rd(4'd4, v); check("R4", v, 32'd260);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 19);
      if (r == 0)
        drive(0, 0, 0, 0, 1, 4'($urandom_range(1, 3)), 32'($urandom_range(0, 500)));
      else
        drive($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
              $urandom_range(0, 2) == 0, 32'($urandom_range(0, 100000)), 0, 0, 0);
      if (i % 150 == 149) check_all("R2 R3 R4 R5");
    end
    check_all("R6");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule